// File: doc/BRIEF.md
# Partial Write Block Merger

This block sits in front of a bridge and widens writes that touch only part of an aligned memory block. When such a write arrives and its sender expects a response, the block reads the whole aligned block from the far-side memory, one 4-byte word at a time. It lays the write's bytes over that image at their offset, and then forwards a single full-block write-invalidate command that carries the original tag.

Writes that already cover the whole aligned block pass through unchanged, and so do writes whose sender expects no response. If any word read fails, the merge is abandoned, an error pulse is raised, and the original write is forwarded as it arrived. While a merged write waits downstream, an undo strobe turns it back into the original partial write, for example after the far side refused the widened write. A write can be merged only once: after an undo, the held write stays in its original form until it is taken.

The block size is a parameter and must be a power of two of at least 4 bytes. One write is in flight at a time, and the block holds off new writes until its output has been accepted.

Top module: `pwm_merger`

## Requirements
- R1: After reset, `wr_ready` is 1, and `busy`, `out_valid`, `rd_req` and `err` are 0.
- R2: A write accepted on `wr_valid && wr_ready` raises `busy` and drops `wr_ready` from the next cycle on. Both stay that way until the cycle after `out_valid && out_ready`. No read is issued while `busy` is 0.
- R3: A merge issues word reads at addresses base, base+4, ... base+BLK_BYTES-4, in that order, where base = `wr_addr & ~(BLK_BYTES-1)`. The read address advances only on `rd_ack`, and `rd_req` stays high until the last word is acknowledged.
- R4: In a merged block, byte j (bits [8j+7:8j] of `out_data`) equals write byte j-off (bits [8(j-off)+7:8(j-off)] of `wr_data`) when off <= j < off+`wr_size`, with off = `wr_addr mod BLK_BYTES`. Every other byte j equals bits [8(j mod 4)+7:8(j mod 4)] of the `rd_data` returned for word j div 4.
- R5: A merged output has `out_inval` = 1 (1 marks write-invalidate, 0 a plain write), `out_size` = BLK_BYTES, `out_addr` = base, and `out_tag` equal to the write's tag.
- R6: A write with offset 0 and `wr_size` = BLK_BYTES issues no reads. It is forwarded with its own address, size, data and tag, and with `out_inval` = 0.
- R7: A write with `wr_need_resp` = 0 issues no reads and is forwarded unchanged with `out_inval` = 0, whatever its size.
- R8: A read acknowledged with `rd_ok` = 0 ends the read phase. No further read is issued, and `err` is 1 for exactly one cycle, the first cycle the output is valid. The original write is forwarded unchanged with `out_inval` = 0.
- R9: `undo` while a merged output is valid and not being accepted turns the output, from the next cycle, into the original address, size and data with `out_inval` = 0. The write is not merged again.
- R10: `undo` while the valid output is not merged leaves every output unchanged.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output fields hold their values, except for the change that R9 makes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Incoming write is presented |
| wr_ready | output | 1 | Block can take a write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_size | input | OFF_W+1 | Write length in bytes, 1..BLK_BYTES, must stay inside the block |
| wr_data | input | BLK_BYTES*8 | Write bytes, first byte in bits [7:0] |
| wr_tag | input | TAG_W | Request tag carried to the output |
| wr_need_resp | input | 1 | Sender expects a response; only such writes are merged |
| busy | output | 1 | A write is being read, merged or held |
| rd_req | output | 1 | Word read request to far-side memory |
| rd_addr | output | ADDR_W | Word read address |
| rd_ack | input | 1 | Read completes this cycle |
| rd_ok | input | 1 | Completed read succeeded |
| rd_data | input | 32 | Read word, lowest address in bits [7:0] |
| out_valid | output | 1 | Outgoing write is presented |
| out_ready | input | 1 | Downstream takes the outgoing write |
| out_addr | output | ADDR_W | Outgoing address |
| out_size | output | OFF_W+1 | Outgoing length in bytes |
| out_data | output | BLK_BYTES*8 | Outgoing data |
| out_tag | output | TAG_W | Outgoing tag |
| out_inval | output | 1 | 1: full-block write-invalidate, 0: plain write |
| undo | input | 1 | Revert a merged output to the original write |
| err | output | 1 | One-cycle pulse after a failed word read |

## Verification
On every cycle, the assertions check the read-address stepping, the shape of a merged output (full size, aligned address), that the output is held while stalled, that an undo reverts a merged output on the next cycle and that it is never merged again, that no read goes out after a failure, and that the error is a single-cycle pulse. Only the bench scenarios can show that the merged bytes are right for every offset and size in the block and that the bypass cases issue no reads and keep their data intact. They also show that an undo restores the exact original fields, and that the right word fails and the original write comes out when a read is refused.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_OUT  = 2'd2
  } pwm_state_e;

  localparam int unsigned WORD_BYTES = 4;

  // Byte lane j of the block is covered by a write at offset off of length size.
  function automatic logic lane_hit(int unsigned lane, int unsigned off, int unsigned size);
    return (lane >= off) && (lane < off + size);
  endfunction

endpackage

// File: rtl/pwm_word_reader.sv
module pwm_word_reader #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              rd_ack,
  input  logic              rd_ok,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              word_we,
  output logic [((BLK_BYTES/4) > 1 ? $clog2(BLK_BYTES/4) : 1)-1:0] word_idx,
  output logic              done,
  output logic              fail
);
  localparam int WORDS = BLK_BYTES / pwm_pkg::WORD_BYTES;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              last_w;

  assign last_w   = (idx_q == IDX_W'(WORDS - 1));
  assign rd_req   = active_q;
  assign rd_addr  = base_q + ADDR_W'({idx_q, 2'b00});
  assign word_we  = active_q && rd_ack && rd_ok;
  assign done     = word_we && last_w;
  assign fail     = active_q && rd_ack && !rd_ok;
  assign word_idx = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      base_q   <= base;
    end else if (done || fail) begin
      active_q <= 1'b0;
    end else if (word_we) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && !done) |=> (rd_req && rd_addr == $past(rd_addr) + ADDR_W'(4)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R8
  stop_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !rd_req);

endmodule

// File: rtl/pwm_block_store.sv
module pwm_block_store #(
  parameter int BLK_BYTES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [((BLK_BYTES/4) > 1 ? $clog2(BLK_BYTES/4) : 1)-1:0] idx,
  input  logic [31:0]            word,
  output logic [BLK_BYTES*8-1:0] blk
);
  localparam int WORDS = BLK_BYTES / pwm_pkg::WORD_BYTES;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        blk[32*w +: 32] <= '0;
      end else if (we && idx == IDX_W'(w)) begin
        blk[32*w +: 32] <= word;
      end
    end
  end

endmodule

// File: rtl/pwm_overlay.sv
module pwm_overlay #(
  parameter int BLK_BYTES = 32
) (
  input  logic [BLK_BYTES*8-1:0]         raw,
  input  logic [BLK_BYTES*8-1:0]         wdata,
  input  logic [$clog2(BLK_BYTES)-1:0]   off,
  input  logic [$clog2(BLK_BYTES):0]     size,
  output logic [BLK_BYTES*8-1:0]         merged
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  for (genvar j = 0; j < BLK_BYTES; j++) begin : g_lane
    logic             hit;
    logic [OFF_W-1:0] src;
    assign hit = pwm_pkg::lane_hit(j, int'(off), int'(size));
    assign src = OFF_W'(j) - off;
    assign merged[8*j +: 8] = hit ? wdata[8*src +: 8] : raw[8*j +: 8];
  end

endmodule

// File: rtl/pwm_merger.sv
module pwm_merger #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32,
  parameter int TAG_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_valid,
  output logic                           wr_ready,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [$clog2(BLK_BYTES):0]     wr_size,
  input  logic [BLK_BYTES*8-1:0]         wr_data,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic                           wr_need_resp,
  output logic                           busy,
  output logic                           rd_req,
  output logic [ADDR_W-1:0]              rd_addr,
  input  logic                           rd_ack,
  input  logic                           rd_ok,
  input  logic [31:0]                    rd_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [ADDR_W-1:0]              out_addr,
  output logic [$clog2(BLK_BYTES):0]     out_size,
  output logic [BLK_BYTES*8-1:0]         out_data,
  output logic [TAG_W-1:0]               out_tag,
  output logic                           out_inval,
  input  logic                           undo,
  output logic                           err
);
  import pwm_pkg::*;

  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int SIZE_W = OFF_W + 1;
  localparam int BLK_W = BLK_BYTES * 8;
  localparam int WORDS = BLK_BYTES / WORD_BYTES;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  function automatic logic [ADDR_W-1:0] blk_base(logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(BLK_BYTES - 1);
  endfunction

  function automatic logic covers_block(logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] s);
    return (a[OFF_W-1:0] == '0) && (s == SIZE_W'(BLK_BYTES));
  endfunction

  pwm_state_e        state_q;
  logic [ADDR_W-1:0] o_addr_q;
  logic [SIZE_W-1:0] o_size_q;
  logic [BLK_W-1:0]  o_data_q;
  logic [TAG_W-1:0]  o_tag_q;
  logic              merged_q;
  logic              err_q;

  // named internal events
  logic              accept_ev;
  logic              need_merge;
  logic              start_ev;
  logic              take_ev;
  logic              revert_ev;
  logic              word_we;
  logic [IDX_W-1:0]  word_idx;
  logic              done_ev;
  logic              fail_ev;
  logic [BLK_W-1:0]  raw_blk;
  logic [BLK_W-1:0]  merged_blk;

  assign wr_ready   = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign accept_ev  = wr_valid && wr_ready;
  assign need_merge = wr_need_resp && !covers_block(wr_addr, wr_size);
  assign start_ev   = accept_ev && need_merge;
  assign out_valid  = (state_q == ST_OUT);
  assign take_ev    = out_valid && out_ready;
  assign revert_ev  = out_valid && !out_ready && undo && merged_q;

  pwm_word_reader #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) reader_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_ev),
    .base     (blk_base(wr_addr)),
    .rd_ack   (rd_ack),
    .rd_ok    (rd_ok),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .word_we  (word_we),
    .word_idx (word_idx),
    .done     (done_ev),
    .fail     (fail_ev)
  );

  pwm_block_store #(.BLK_BYTES(BLK_BYTES)) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (word_we),
    .idx   (word_idx),
    .word  (rd_data),
    .blk   (raw_blk)
  );

  pwm_overlay #(.BLK_BYTES(BLK_BYTES)) overlay_i (
    .raw    (raw_blk),
    .wdata  (o_data_q),
    .off    (o_addr_q[OFF_W-1:0]),
    .size   (o_size_q),
    .merged (merged_blk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      o_addr_q <= '0;
      o_size_q <= '0;
      o_data_q <= '0;
      o_tag_q  <= '0;
      merged_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= fail_ev;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_ev) begin
            o_addr_q <= wr_addr;
            o_size_q <= wr_size;
            o_data_q <= wr_data;
            o_tag_q  <= wr_tag;
            merged_q <= 1'b0;
            state_q  <= need_merge ? ST_READ : ST_OUT;
          end
        end
        ST_READ: begin
          if (done_ev) begin
            merged_q <= 1'b1;
            state_q  <= ST_OUT;
          end else if (fail_ev) begin
            merged_q <= 1'b0;
            state_q  <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (take_ev) begin
            merged_q <= 1'b0;
            state_q  <= ST_IDLE;
          end else if (revert_ev) begin
            merged_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_inval = merged_q;
  assign out_addr  = merged_q ? blk_base(o_addr_q) : o_addr_q;
  assign out_size  = merged_q ? SIZE_W'(BLK_BYTES) : o_size_q;
  assign out_data  = merged_q ? merged_blk : o_data_q;
  assign out_tag   = o_tag_q;
  assign err       = err_q;

  // R2
  read_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (busy && !wr_ready));

  // R5
  blk_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inval) |-> (out_size == SIZE_W'(BLK_BYTES) && out_addr[OFF_W-1:0] == '0));

  // R11
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !undo) |=>
      (out_valid && $stable(out_addr) && $stable(out_size) && $stable(out_data)
       && $stable(out_tag) && $stable(out_inval)));

  // R9
  undo_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inval && undo && !out_ready) |=> (out_valid && !out_inval));

  // R9
  merge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_inval) |=> !out_inval);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R8
  err_orig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (out_valid && !out_inval));

endmodule

// File: tb/pwm_merger_tb.sv
module pwm_merger_tb_top;
  localparam int ADDR_W = 32;
  localparam int BLK    = 16;
  localparam int TAG_W  = 8;
  localparam int SW     = 5;
  localparam int BW     = BLK * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              wr_valid;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr;
  logic [SW-1:0]     wr_size;
  logic [BW-1:0]     wr_data;
  logic [TAG_W-1:0]  wr_tag;
  logic              wr_need_resp;
  logic              busy;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_ack;
  logic              rd_ok;
  logic [31:0]       rd_data;
  logic              out_valid;
  logic              out_ready;
  logic [ADDR_W-1:0] out_addr;
  logic [SW-1:0]     out_size;
  logic [BW-1:0]     out_data;
  logic [TAG_W-1:0]  out_tag;
  logic              out_inval;
  logic              undo;
  logic              err;

  pwm_merger #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .wr_tag(wr_tag), .wr_need_resp(wr_need_resp),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_ok(rd_ok),
    .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_size(out_size), .out_data(out_data), .out_tag(out_tag), .out_inval(out_inval),
    .undo(undo), .err(err)
  );

  // far-side memory model
  int unsigned       lat;
  logic              fail_en;
  logic [ADDR_W-1:0] fail_addr;
  int unsigned       wait_cnt;

  function automatic logic [31:0] mem_word(logic [ADDR_W-1:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]} + 32'h0101_0101;
  endfunction

  assign rd_ack  = rd_req && (wait_cnt >= lat);
  assign rd_ok   = !(fail_en && rd_addr == fail_addr);
  assign rd_data = mem_word(rd_addr);

  always_ff @(posedge clk) begin
    if (rd_req && !rd_ack) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
  end

  logic [ADDR_W-1:0] rd_log [64];
  int unsigned       n_rd = 0;
  always @(posedge clk) begin
    if (rd_req && rd_ack) begin
      rd_log[n_rd % 64] <= rd_addr;
      n_rd <= n_rd + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  function automatic logic [BW-1:0] exp_merge(logic [ADDR_W-1:0] a, int sz, logic [BW-1:0] d);
    logic [BW-1:0] r;
    logic [ADDR_W-1:0] base;
    int off;
    base = a & ~ADDR_W'(BLK - 1);
    off  = int'(a % BLK);
    for (int j = 0; j < BLK; j++) begin
      if (j >= off && j < off + sz) r[8*j +: 8] = d[8*(j - off) +: 8];
      else r[8*j +: 8] = mem_word(base + ADDR_W'((j / 4) * 4)) >> (8 * (j % 4));
    end
    return r;
  endfunction

  function automatic logic [BW-1:0] pattern(int seed);
    logic [BW-1:0] d;
    for (int k = 0; k < BLK; k++) d[8*k +: 8] = 8'((k * 37) ^ (seed * 11) ^ 8'hC5);
    return d;
  endfunction

  task automatic present(input logic [ADDR_W-1:0] a, input int sz, input logic [BW-1:0] d,
                         input logic [TAG_W-1:0] t, input logic nr);
    @(negedge clk);
    wr_addr = a; wr_size = SW'(sz); wr_data = d; wr_tag = t; wr_need_resp = nr;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_out(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (out_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic take_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // one write, full check of the output; returns nothing
  task automatic run_one(input logic [ADDR_W-1:0] a, input int sz, input int seed, input logic nr);
    logic [BW-1:0] d, ed;
    logic [ADDR_W-1:0] base;
    logic [TAG_W-1:0] t;
    int unsigned rd0;
    bit merge, seen, ok;
    d = pattern(seed);
    t = TAG_W'(seed * 3 + 1);
    base = a & ~ADDR_W'(BLK - 1);
    merge = nr && !((a % BLK) == 0 && sz == BLK);
    rd0 = n_rd;
    present(a, sz, d, t, nr);
    if (merge) chk(busy && !wr_ready, "R2 busy during read", BW'({busy, wr_ready}), BW'(2'b10));
    wait_out(seen);
    chk(seen, "R2 output appears", BW'(seen), BW'(1));
    if (merge) begin
      ed = exp_merge(a, sz, d);
      chk(out_data == ed, "R4 merged bytes", out_data, ed);
      chk(out_inval && out_size == SW'(BLK) && out_addr == base && out_tag == t,
          "R5 merged fields", BW'({out_inval, out_size, out_addr, out_tag}),
          BW'({1'b1, SW'(BLK), base, t}));
      ok = (n_rd - rd0 == BLK / 4);
      for (int k = 0; k < BLK / 4; k++)
        if (rd_log[(rd0 + k) % 64] != base + ADDR_W'(4 * k)) ok = 0;
      chk(ok, "R3 read sequence", BW'(n_rd - rd0), BW'(BLK / 4));
    end else begin
      chk(!out_inval && out_addr == a && out_size == SW'(sz) && out_data == d && out_tag == t,
          nr ? "R6 full block bypass" : "R7 no-response bypass",
          BW'({out_inval, out_addr, out_size}), BW'({1'b0, a, SW'(sz)}));
      chk(n_rd == rd0, nr ? "R6 no reads" : "R7 no reads", BW'(n_rd - rd0), BW'(0));
    end
    take_out();
    chk(!busy && wr_ready && !out_valid, "R2 idle after take",
        BW'({busy, wr_ready, out_valid}), BW'(3'b010));
  endtask

  initial begin
    bit seen;
    logic [BW-1:0] d;
    logic [ADDR_W-1:0] a;
    int unsigned rd0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_size = '0; wr_data = '0; wr_tag = '0;
    wr_need_resp = 1'b0; out_ready = 1'b0; undo = 1'b0; lat = 0; fail_en = 1'b0; fail_addr = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(wr_ready && !busy && !out_valid && !rd_req && !err, "R1 reset state",
        BW'({wr_ready, busy, out_valid, rd_req, err}), BW'(5'b10000));
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every offset and size in the block, with varying read latency
    for (int off = 0; off < BLK; off++) begin
      for (int sz = 1; sz <= BLK - off; sz++) begin
        lat = (off + sz) % 3;
        run_one(ADDR_W'(32'h0000_1000 + 16 * (off + sz) + off), sz, off * 16 + sz, 1'b1);
      end
    end

    // R7: no-response writes of various shapes
    for (int k = 0; k < 6; k++) begin
      lat = 1;
      run_one(ADDR_W'(32'h0000_2000 + 16 * k + k * 2), 1 + k, 500 + k, 1'b0);
    end

    // R8: read failure on the third word
    lat = 1;
    a = 32'h0000_3005;
    d = pattern(777);
    fail_en = 1'b1; fail_addr = 32'h0000_3008;
    rd0 = n_rd;
    present(a, 3, d, 8'h5E, 1'b1);
    wait_out(seen);
    chk(seen && err, "R8 err with output", BW'({seen, err}), BW'(2'b11));
    chk(!out_inval && out_addr == a && out_size == SW'(3) && out_data == d && out_tag == 8'h5E,
        "R8 original forwarded", BW'({out_inval, out_addr, out_size}), BW'({1'b0, a, SW'(3)}));
    chk(n_rd - rd0 == 3 && rd_log[(rd0 + 2) % 64] == fail_addr, "R8 reads stop at failure",
        BW'(n_rd - rd0), BW'(3));
    @(negedge clk);
    chk(!err && !rd_req, "R8 err single cycle", BW'({err, rd_req}), BW'(0));
    take_out();
    fail_en = 1'b0;

    // R9 / R10: undo on a merged output, then again on the reverted one
    lat = 0;
    a = 32'h0000_4006;
    d = pattern(901);
    present(a, 5, d, 8'hA7, 1'b1);
    wait_out(seen);
    chk(out_inval && out_data == exp_merge(a, 5, d), "R9 merged before undo",
        out_data, exp_merge(a, 5, d));
    undo = 1'b1;
    @(negedge clk);
    undo = 1'b0;
    chk(out_valid && !out_inval && out_addr == a && out_size == SW'(5) && out_data == d
        && out_tag == 8'hA7, "R9 undo restores original",
        BW'({out_inval, out_addr, out_size}), BW'({1'b0, a, SW'(5)}));
    repeat (3) @(negedge clk);
    chk(out_valid && !out_inval && out_data == d, "R11 held after undo", out_data, d);
    undo = 1'b1;
    @(negedge clk);
    undo = 1'b0;
    chk(out_valid && !out_inval && out_addr == a && out_data == d, "R10 second undo no effect",
        out_data, d);
    take_out();

    // R10: undo on a bypassed output
    a = 32'h0000_5000;
    d = pattern(33);
    present(a, BLK, d, 8'h11, 1'b1);
    wait_out(seen);
    undo = 1'b1;
    @(negedge clk);
    undo = 1'b0;
    chk(out_valid && !out_inval && out_addr == a && out_size == SW'(BLK) && out_data == d,
        "R10 undo on bypass no effect", out_data, d);
    // R11: stall with a merged output
    take_out();
    a = 32'h0000_6009;
    d = pattern(44);
    present(a, 2, d, 8'h22, 1'b1);
    wait_out(seen);
    repeat (4) @(negedge clk);
    chk(out_valid && out_inval && out_data == exp_merge(a, 2, d) && out_tag == 8'h22,
        "R11 stalled merged output held", out_data, exp_merge(a, 2, d));
    take_out();

    finish_run();
  end

endmodule